// File: doc/BRIEF.md
# Transmit Bit-Slip Delay Unit

This block sits at the tail of a transmit coding chain, after the line encoder and just ahead of the serializer. It delays the outgoing bit stream by a programmable number of bit positions, working entirely on parallel words. Each output word is assembled from the word being presented now and the word presented one cycle earlier. The stream therefore stays continuous across word boundaries, and no bit is dropped or repeated while the delay is held constant.

The lane width is selectable at run time. In narrow mode the word is 10 bits and travels on the low half of the bus. In wide mode the word is 20 bits. Bit 0 of a word is the first bit sent on the line. The delay amount is sampled together with each word, so a new value applies starting with the word it arrives with.

Top module: `tx_bitslip`

## Requirements
- R1: While `rst_n` is low, `dout` is all zeros and the stored previous word is cleared. The first word after reset is preceded by zero bits.
- R2: With `slip` = 0, `dout` equals the active part of `din` from the previous cycle. That is exactly one register stage of latency.
- R3: In narrow mode (`wide` = 0, W = 10), output bit i is `din[i-k]` of the current word for i >= k. For i < k it is bit W-k+i of the previous word. `dout[19:10]` is zero and `din[19:10]` has no effect on the output.
- R4: In wide mode (`wide` = 1, W = 20), the same bit mapping as R3 holds over all 20 bits.
- R5: A `slip` value of W or more is treated as W-1. That is 9 in narrow mode and 19 in wide mode.
- R6: `slip` and `wide` are sampled with each word. A changed value shapes the output word built from the word presented in the same cycle. The history bits still come from the previous word as it was stored.
- R7: The stored previous word keeps only the active bits of its mode. After a switch from narrow to wide, bits 10..19 of the history are zero. After a switch from wide to narrow, only history bits 0..9 are used.
- R8: With `slip` held constant at k, the serial stream formed by the output words (bit 0 first) is the input stream delayed by exactly k bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 20 | Encoded word in; low 10 bits in narrow mode |
| slip | input | 5 | Delay in bit positions, saturated to W-1 |
| wide | input | 1 | 1 selects the 20-bit word, 0 the 10-bit word |
| dout | output | 20 | Delayed word to the serializer |

## Verification
A change of delay and a change of width mode can land on the same word boundary. In that cycle the old history must be read under the new width and the new shift amount at once. The bench provokes this by toggling `wide` while it also steps `slip`, including values past the saturation limit. A behavioural per-bit model then computes, on every clock, where each output bit must come from.

// File: rtl/tx_bitslip.sv
module tx_bitslip #(
  parameter int WS = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [2*WS-1:0]              din,
  input  logic [$clog2(2*WS)-1:0]      slip,
  input  logic                         wide,
  output logic [2*WS-1:0]              dout
);
  localparam int WD = 2 * WS;

  logic [WD-1:0]   hist;
  logic [WD-1:0]   cur;
  logic [2*WD-1:0] joined;
  logic [2*WD-1:0] shifted;
  logic [WD-1:0]   nxt;
  int              wlen;
  int              kk;

  assign cur = wide ? din : {{WS{1'b0}}, din[WS-1:0]};

  always_comb begin
    wlen = wide ? WD : WS;
    kk   = (int'(slip) >= wlen) ? wlen - 1 : int'(slip);
  end

  assign joined  = wide ? {cur, hist} : {{WD{1'b0}}, cur[WS-1:0], hist[WS-1:0]};
  assign shifted = joined >> (wlen - kk);
  assign nxt     = wide ? shifted[WD-1:0] : {{WS{1'b0}}, shifted[WS-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      dout <= '0;
    end else begin
      hist <= cur;
      dout <= nxt;
    end
  end
endmodule

module tx_bitslip_chk #(
  parameter int WS = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [2*WS-1:0]         din,
  input logic [$clog2(2*WS)-1:0] slip,
  input logic                    wide,
  input logic [2*WS-1:0]         dout
);
  localparam int WD = 2 * WS;

  assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slip == 0 && wide) |=> dout == $past(din));

  assert_narrow_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slip == 0 && !wide) |=> dout[WS-1:0] == $past(din[WS-1:0]));

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |=> dout[WD-1:WS] == '0);

  assert_wide_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && slip == 1) |=> dout[WD-1:1] == $past(din[WD-2:0]));

  assert_sat_wide_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && int'(slip) >= WD) |=> dout[WD-1] == $past(din[0]));

  assert_sat_narrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && int'(slip) >= WS) |=> dout[WS-1] == $past(din[0]));
endmodule

bind tx_bitslip tx_bitslip_chk #(.WS(WS)) u_chk (
  .clk(clk), .rst_n(rst_n), .din(din), .slip(slip), .wide(wide), .dout(dout)
);

// File: tb/sim_tx_bitslip.sv
module sim_tx_bitslip;
  localparam int PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [19:0] din = '0;
  logic [4:0]  slip = '0;
  logic        wide = 0;
  logic [19:0] dout;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [19:0] exp_word = '0;
  string       exp_tag = "R1";
  bit          have_exp = 0;
  logic [19:0] mprev = '0;

  bit sq[$];
  bit sq_on = 0;

  tx_bitslip u0 (.clk(clk), .rst_n(rst_n), .din(din), .slip(slip), .wide(wide), .dout(dout));

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input logic [19:0] act, input logic [19:0] expv, input string tag);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: dout=%h expected %h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic step(input logic [19:0] d, input int k, input bit w, input string tag);
    int wl, kk;
    logic [19:0] c, e;
    @(negedge clk);
    if (have_exp) check(dout, exp_word, exp_tag);
    din  = d;
    slip = 5'(k);
    wide = w;
    wl = w ? 20 : 10;
    kk = (k >= wl) ? wl - 1 : k;
    c = w ? d : {10'b0, d[9:0]};
    e = '0;
    for (int i = 0; i < wl; i++)
      e[i] = (i >= kk) ? c[i-kk] : mprev[wl-kk+i];
    mprev = c;
    exp_word = e;
    exp_tag = tag;
    have_exp = 1;
  endtask

  task automatic stream_run(input int k, input bit w, input int n);
    int wl, got;
    bit ok;
    wl = w ? 20 : 10;
    sq.delete();
    for (int i = 0; i < k; i++) sq.push_back(1'b0);
    step(20'(mprev), k, w, "R8");
    for (int j = 0; j < n; j++) begin
      logic [19:0] d;
      d = 20'($urandom);
      for (int i = 0; i < wl; i++) sq.push_back(d[i]);
      step(d, k, w, "R8");
      @(posedge clk);
      #1;
      if (j > 0) begin
        ok = 1;
        for (int i = 0; i < wl; i++) if (dout[i] !== sq.pop_front()) ok = 0;
        checks++;
        if (!ok) begin
          errors++;
          $display("FAIL R8: stream word %0d dout=%h expected delayed by %0d", j, dout, k);
        end
      end else begin
        for (int i = 0; i < wl; i++) got = int'(sq.pop_front());
      end
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) begin
      @(negedge clk);
      check(dout, 20'h0, "R1");
    end
    rst_n = 1;
    mprev = '0;
    exp_word = '0;
    exp_tag = "R1";
    have_exp = 1;

    step(20'h3FF, 3, 0, "R1");
    step(20'h00000, 0, 0, "R1");

    for (int j = 0; j < 8; j++) step(20'($urandom), 0, 1, "R2");
    for (int j = 0; j < 8; j++) step(20'($urandom), 0, 0, "R2");

    for (int k = 0; k < 10; k++)
      for (int j = 0; j < 3; j++) step(20'($urandom), k, 0, "R3");
    step(20'hFFC00, 4, 0, "R3");
    step(20'hAAC00, 4, 0, "R3");

    for (int k = 0; k < 20; k++)
      for (int j = 0; j < 3; j++) step(20'($urandom), k, 1, "R4");

    for (int k = 10; k < 32; k++) step(20'($urandom), k, 0, "R5");
    for (int k = 20; k < 32; k++) step(20'($urandom), k, 1, "R5");

    for (int j = 0; j < 40; j++) step(20'($urandom), int'($urandom_range(0, 31)), 1, "R6");
    for (int j = 0; j < 40; j++) step(20'($urandom), int'($urandom_range(0, 31)), 0, "R6");

    for (int j = 0; j < 60; j++) step(20'($urandom), int'($urandom_range(0, 31)), j[0], "R7");
    step(20'hFFFFF, 5, 0, "R7");
    step(20'h00000, 15, 1, "R7");
    step(20'h00000, 15, 1, "R7");

    stream_run(0, 1, 6);
    stream_run(7, 0, 8);
    stream_run(13, 1, 8);
    stream_run(9, 0, 8);

    step(20'h0, 0, 0, "R8");
    step(20'h0, 0, 0, "R8");
    finish_run();
  end
endmodule